// File: doc/BRIEF.md
# Three-Wire Latched Configuration Receiver

This block takes configuration words from a host over three lines: a serial clock, a data line and a latch strobe. Each data bit is taken in on a rising edge of the serial clock and pushed into a word-wide shift register, most significant bit first. A rising edge on the latch strobe then copies the word into one of two holding registers. The bit sent last picks which one. The three lines are brought into the system clock domain through flop synchronizers, and all edge detection runs on the system clock.

One holding register carries the reference divide ratio and the detector polarity flag. The other carries the feedback divide value and a power-down flag. The decoded fields leave the block as registered outputs that feed the divider, detector and power logic. The receiver itself is never powered down, so the host can still rewrite either register while the power-down flag is set.

Top module: `cfg_wire_latch`

## Requirements
- R1: After reset, ref_div reads 2, det_pol reads 0, fb_div reads 0 and pwr_down reads 0.
- R2: Data is taken on each synchronized rising edge of ser_clk, most significant bit first. Only the last 18 bits shifted in before a latch count, and any earlier bits are pushed out.
- R3: Word bit 0 (the last bit sent) is the address. 0 selects the reference register and 1 selects the feedback register. A latch leaves the register that was not addressed unchanged.
- R4: In a reference word, bits 10..1 give ref_div and bit 11 gives det_pol. Bits 17..12 have no effect.
- R5: In a feedback word, bits 15..1 give fb_div and bit 16 gives pwr_down. Bit 17 has no effect.
- R6: A reference divide value of 0 or 1 is loaded as 2. Values from 2 to 1023 load unchanged.
- R7: Outputs change only on a rising edge of ser_le. Shifting bits while ser_le is low or high, and a falling edge of ser_le, leave every output unchanged.
- R8: While pwr_down is 1, the block still shifts and latches words to both addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; rising edge loads the addressed register |
| ref_div | output | 10 | Reference divide ratio, at least 2 |
| det_pol | output | 1 | Phase detector polarity flag |
| fb_div | output | 15 | Feedback divide value |
| pwr_down | output | 1 | Power-down flag |

## Verification
The bench builds the block with its default parameters. These are an 18-bit word, a 10-bit reference field, a 15-bit feedback field, a floor of 2 and two synchronizer stages. At these sizes both field boundaries and the unused top bit can be reached with directed words, and so can the clamp values 0 and 1 and the upper limit 1023. A run of 22 bits checks that stale leading bits are discarded. Random words sent to both addresses check field decoding across the full value range.

// File: rtl/cfg_wire_latch.sv
module cfg_wire_latch #(
  parameter int WORD_W    = 18,
  parameter int RDIV_W    = 10,
  parameter int NDIV_W    = 15,
  parameter int RDIV_MIN  = 2,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [RDIV_W-1:0] ref_div,
  output logic              det_pol,
  output logic [NDIV_W-1:0] fb_div,
  output logic              pwr_down
);

  localparam int R_POL_BIT = RDIV_W + 1;
  localparam int N_PD_BIT  = NDIV_W + 1;
  localparam logic [RDIV_W-1:0] RMIN_V = RDIV_MIN[RDIV_W-1:0];

  logic [SYNC_N-1:0] ck_s, dt_s, le_s;
  logic              ck_d, le_d;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
      le_s <= '0;
      ck_d <= 1'b0;
      le_d <= 1'b0;
    end else begin
      ck_s <= {ck_s[SYNC_N-2:0], ser_clk};
      dt_s <= {dt_s[SYNC_N-2:0], ser_dat};
      le_s <= {le_s[SYNC_N-2:0], ser_le};
      ck_d <= ck_s[SYNC_N-1];
      le_d <= le_s[SYNC_N-1];
    end
  end

  wire ck_rise = ck_s[SYNC_N-1] & ~ck_d;
  wire le_rise = le_s[SYNC_N-1] & ~le_d;
  wire dat_now = dt_s[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (ck_rise) sr <= {sr[WORD_W-2:0], dat_now};
  end

  wire [RDIV_W-1:0] r_raw = sr[RDIV_W:1];
  wire [RDIV_W-1:0] r_fix = (r_raw < RMIN_V) ? RMIN_V : r_raw;
  wire              sel_n = sr[0];

  logic unused_hi;
  assign unused_hi = ^sr[WORD_W-1:N_PD_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div  <= RMIN_V;
      det_pol  <= 1'b0;
      fb_div   <= '0;
      pwr_down <= 1'b0;
    end else if (le_rise) begin
      if (sel_n) begin
        fb_div   <= sr[NDIV_W:1];
        pwr_down <= sr[N_PD_BIT];
      end else begin
        ref_div  <= r_fix;
        det_pol  <= sr[R_POL_BIT];
      end
    end
  end

  a_r6_ref_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ref_div >= RMIN_V);

  a_r7_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(ref_div) && $stable(det_pol) && $stable(fb_div) && $stable(pwr_down));

  a_r3_ref_write_keeps_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !sel_n) |=> $stable(fb_div) && $stable(pwr_down));

  a_r3_fb_write_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sel_n) |=> $stable(ref_div) && $stable(det_pol));

  a_r2_shift_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
    ck_rise |=> sr[0] == $past(dat_now));

endmodule

// File: tb/cfg_wire_latch_tb_top.sv
module cfg_wire_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [9:0]  ref_div;
  logic        det_pol;
  logic [14:0] fb_div;
  logic        pwr_down;

  int checks = 0;
  int errors = 0;
  logic [9:0]  e_ref = 10'd2;
  logic        e_pol = 1'b0;
  logic [14:0] e_fb  = '0;
  logic        e_pd  = 1'b0;

  always #2.5 clk = ~clk;

  cfg_wire_latch dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_div(ref_div), .det_pol(det_pol), .fb_div(fb_div), .pwr_down(pwr_down)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " ref_div"}, 32'(ref_div), 32'(e_ref));
    chk({tag, " det_pol"}, 32'(det_pol), 32'(e_pol));
    chk({tag, " fb_div"},  32'(fb_div),  32'(e_fb));
    chk({tag, " pwr_down"}, 32'(pwr_down), 32'(e_pd));
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic latch();
    ser_le = 1'b1;
    repeat (6) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [17:0] r_word(input logic [5:0] hi, input logic pol, input logic [9:0] d);
    return {hi, pol, d, 1'b0};
  endfunction

  function automatic logic [17:0] n_word(input logic hi, input logic pd, input logic [14:0] d);
    return {hi, pd, d, 1'b1};
  endfunction

  task automatic send(input logic [17:0] w);
    shift_bits(32'(w), 18);
    latch();
    if (w[0]) begin
      e_fb = w[15:1]; e_pd = w[16];
    end else begin
      e_ref = (w[10:1] < 10'd2) ? 10'd2 : w[10:1]; e_pol = w[11];
    end
  endtask

  task automatic t_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_ref_fields();
    send(r_word(6'h3F, 1'b1, 10'd1023));
    chk_all("R4 ref max with high junk");
    send(r_word(6'h00, 1'b0, 10'd517));
    chk_all("R4 ref mid");
  endtask

  task automatic t_fb_fields();
    send(n_word(1'b1, 1'b0, 15'h7FFF));
    chk_all("R5 fb max bit17 ignored");
    send(n_word(1'b0, 1'b1, 15'd992));
    chk_all("R5 fb with power-down");
    send(n_word(1'b0, 1'b0, 15'd12345));
    chk_all("R3 fb write keeps ref");
  endtask

  task automatic t_clamp();
    send(r_word(6'h00, 1'b0, 10'd0));
    chk("R6 ref 0 clamps", 32'(ref_div), 32'd2);
    send(r_word(6'h00, 1'b1, 10'd1));
    chk("R6 ref 1 clamps", 32'(ref_div), 32'd2);
    send(r_word(6'h00, 1'b0, 10'd3));
    chk("R6 ref 3 passes", 32'(ref_div), 32'd3);
    send(r_word(6'h00, 1'b0, 10'd2));
    chk_all("R6 ref 2 passes");
  endtask

  task automatic t_no_latch();
    shift_bits(32'(n_word(1'b0, 1'b1, 15'd777)), 18);
    chk_all("R7 shift with le low");
    ser_le = 1'b1;
    repeat (6) @(negedge clk);
    e_fb = 15'd777; e_pd = 1'b1;
    chk_all("R7 le rise loads");
    shift_bits(32'(r_word(6'h00, 1'b1, 10'd900)), 18);
    chk_all("R7 shift with le high");
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
    chk_all("R7 le fall no load");
    latch();
    e_ref = 10'd900; e_pol = 1'b1;
    chk_all("R7 next rise loads held word");
  endtask

  task automatic t_overlong();
    shift_bits(32'h0000_000F, 4);
    shift_bits(32'(r_word(6'h00, 1'b0, 10'd44)), 18);
    latch();
    e_ref = 10'd44; e_pol = 1'b0;
    chk_all("R2 leading bits discarded");
  endtask

  task automatic t_powered_down();
    send(n_word(1'b0, 1'b1, 15'd2000));
    chk("R8 pd set", 32'(pwr_down), 32'd1);
    send(r_word(6'h00, 1'b0, 10'd321));
    chk_all("R8 ref latch while down");
    send(n_word(1'b0, 1'b1, 15'd3001));
    chk_all("R8 fb latch while down");
    send(n_word(1'b0, 1'b0, 15'd3001));
    chk_all("R8 power back up");
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) begin
      logic [17:0] w;
      w = 18'($urandom);
      send(w);
      chk_all(w[0] ? "R5 random fb" : "R4 random ref");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ref_fields();
    t_fb_fields();
    t_clamp();
    t_no_latch();
    t_overlong();
    t_powered_down();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule